// File: doc/BRIEF.md
# Rectangular-to-Polar Converter

This block takes one complex operand and returns its polar form. The operand has a signed 32-bit real part and a signed 32-bit imaginary part. The result packs the magnitude and the angle into a single 64-bit word. The operand is chosen from two 64-bit inputs by a select line. The block is a sequential functional unit beside a complex ALU and uses the same single-cycle request/complete handshake.

On an accepted request the block latches the selected operand. If the real part is negative, it first turns the vector by a quarter turn into the right half-plane. It then runs a fixed number of shift-and-add vectoring iterations, one per clock, and drives the residual imaginary part to zero while it accumulates the angle from a table of arctangent constants. A final cycle scales the grown real part by the inverse iteration gain, saturates it to 32 bits and publishes the result with a one-cycle completion pulse. Requests that arrive while a conversion is running are dropped.

Top module: `polar_conv`

## Requirements
- R1: During and after a synchronous active-high reset, `done` is 0 and `result` is 0 until the first conversion completes.
- R2: The operand is `op_b` when `sel_b` is 1 and `op_a` when it is 0, sampled in the cycle `start` is accepted. Bits [63:32] hold the signed real part and bits [31:0] hold the signed imaginary part.
- R3: `result[63:32]` is the magnitude sqrt(re²+im²) as an unsigned integer, within 4 + m·2⁻²⁴ of the exact value m.
- R4: `result[31:0]` is the angle atan2(im, re) as a signed value in which 2³¹ stands for 180 degrees, so it wraps at ±180. It is within 256 + 2³¹/m steps of the exact value, counted modulo 2³².
- R5: Operands from all four quadrants and on all four axes are converted correctly. The negative real axis gives an angle of 0x8000_0000.
- R6: When the exact magnitude exceeds 2³¹−1, `result[63:32]` is exactly 0x7FFF_FFFF. The magnitude field never has bit 63 set.
- R7: An operand of 0+0j gives `result` equal to 0 in both fields.
- R8: `done` is high for exactly one cycle, ITER+2 cycles after the cycle in which `start` was accepted. With the default ITER=32 this is 34 cycles, within the 38-cycle budget.
- R9: A `start` pulse while a conversion is running is ignored. It changes neither the result nor the completion time, and it causes no extra `done` pulse.
- R10: `result` holds its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to convert the selected operand |
| sel_b | input | 1 | 1 selects `op_b`, 0 selects `op_a` |
| op_a | input | 64 | Operand A: {real[31:0], imag[31:0]} |
| op_b | input | 64 | Operand B: {real[31:0], imag[31:0]} |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 64 | {magnitude[31:0], angle[31:0]} |

## Verification
The bench builds the converter with its defaults: ITER=32 iterations and GUARD=4 fractional guard bits. At these values the angle resolves to a few steps for large vectors, and the 34-cycle latency can be compared against the 38-cycle budget. Full-scale operands such as −2³¹−2³¹j exercise the wide datapath and the magnitude clamp. Exact references are computed in floating point from the operand. The bench also checks the sign flips of the pre-rotation on every axis, including the 180-degree wrap, and the rejection of a request that arrives mid-conversion.

// File: rtl/polar_conv.sv
module polar_conv #(
  parameter int          ITER     = 32,
  parameter int          GUARD    = 4,
  parameter logic [31:0] GAIN_Q32 = 32'd2608131497
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        sel_b,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        done,
  output logic [63:0] result
);

  localparam int XW = 35 + GUARD;
  localparam int MW = XW - GUARD;
  localparam int PW = XW + 32;
  localparam int CW = $clog2(ITER + 1);
  localparam logic [PW-1:0] RND = PW'(1) << (31 + GUARD);

  logic                 busy, scale, zero_q;
  logic [CW-1:0]        step;
  logic signed [XW-1:0] x, y;
  logic [31:0]          z;

  function automatic logic [31:0] atan_step(input int idx);
    case (idx)
      0:  atan_step = 32'd536870912;
      1:  atan_step = 32'd316933406;
      2:  atan_step = 32'd167458907;
      3:  atan_step = 32'd85004756;
      4:  atan_step = 32'd42667331;
      5:  atan_step = 32'd21354465;
      6:  atan_step = 32'd10679838;
      7:  atan_step = 32'd5340245;
      8:  atan_step = 32'd2670163;
      9:  atan_step = 32'd1335087;
      10: atan_step = 32'd667544;
      11: atan_step = 32'd333772;
      12: atan_step = 32'd166886;
      13: atan_step = 32'd83443;
      14: atan_step = 32'd41722;
      15: atan_step = 32'd20861;
      16: atan_step = 32'd10430;
      17: atan_step = 32'd5215;
      18: atan_step = 32'd2608;
      19: atan_step = 32'd1304;
      20: atan_step = 32'd652;
      21: atan_step = 32'd326;
      22: atan_step = 32'd163;
      23: atan_step = 32'd81;
      24: atan_step = 32'd41;
      25: atan_step = 32'd20;
      26: atan_step = 32'd10;
      27: atan_step = 32'd5;
      28: atan_step = 32'd3;
      29: atan_step = 32'd1;
      30: atan_step = 32'd1;
      default: atan_step = 32'd0;
    endcase
  endfunction

  wire [63:0] src    = sel_b ? op_b : op_a;
  wire        accept = start && !busy;

  wire signed [XW-1:0] re_w = {{(XW-32-GUARD){src[63]}}, src[63:32], {GUARD{1'b0}}};
  wire signed [XW-1:0] im_w = {{(XW-32-GUARD){src[31]}}, src[31:0],  {GUARD{1'b0}}};

  wire signed [XW-1:0] x_sh = x >>> step;
  wire signed [XW-1:0] y_sh = y >>> step;
  wire                 up   = !y[XW-1];

  wire [MW-1:0] mag_w = MW'((({{32{1'b0}}, x} * {{XW{1'b0}}, GAIN_Q32}) + RND) >> (32 + GUARD));
  wire          sat   = |mag_w[MW-1:31];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      scale  <= 1'b0;
      zero_q <= 1'b0;
      step   <= '0;
      x      <= '0;
      y      <= '0;
      z      <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        scale  <= 1'b0;
        step   <= '0;
        zero_q <= (src == 64'd0);
        if (!src[63]) begin
          x <= re_w;
          y <= im_w;
          z <= 32'h0000_0000;
        end else if (!src[31]) begin
          x <= im_w;
          y <= -re_w;
          z <= 32'h4000_0000;
        end else begin
          x <= -im_w;
          y <= re_w;
          z <= 32'hC000_0000;
        end
      end else if (busy && !scale) begin
        if (up) begin
          x <= x + y_sh;
          y <= y - x_sh;
          z <= z + atan_step(int'(step));
        end else begin
          x <= x - y_sh;
          y <= y + x_sh;
          z <= z - atan_step(int'(step));
        end
        step <= step + CW'(1);
        if (step == CW'(ITER - 1)) scale <= 1'b1;
      end else if (scale) begin
        scale  <= 1'b0;
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= {sat ? 32'h7FFF_FFFF : mag_w[31:0], zero_q ? 32'd0 : z};
      end
    end
  end

endmodule

// File: rtl/polar_conv_chk.sv
module polar_conv_chk #(
  parameter int MAX_CYC = 38
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        sel_b,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        done,
  input logic [63:0] result
);

  logic       pend, zero_q;
  logic [7:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      zero_q <= 1'b0;
      cnt    <= '0;
    end else if (start && (!pend || done)) begin
      pend   <= 1'b1;
      cnt    <= 8'd1;
      zero_q <= ((sel_b ? op_b : op_a) == 64'd0);
    end else if (done) begin
      pend <= 1'b0;
    end else if (pend && cnt != 8'hFF) begin
      cnt <= cnt + 8'd1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_LATENCY_BUDGET: assert property (@(posedge clk) disable iff (rst) pend |-> cnt <= 8'(MAX_CYC)); // R8
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst) done |-> pend); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result)); // R10
  AST_MAG_NONNEG: assert property (@(posedge clk) disable iff (rst) done |-> !result[63]); // R6
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst) (done && zero_q) |-> result == 64'd0); // R7

endmodule

bind polar_conv polar_conv_chk #(.MAX_CYC(38)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sel_b(sel_b),
  .op_a(op_a), .op_b(op_b), .done(done), .result(result)
);

// File: tb/polar_conv_test.sv
`timescale 1ns/1ps
module polar_conv_test;

  localparam int ITER = 32;
  localparam int NV   = 16;
  localparam real PI  = 3.14159265358979323846;

  // bit 64 = sel_b, bits 63:0 = {re, im}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'h000F4240, 32'h00000000},
    {1'b0, 32'h00000000, 32'h000F4240},
    {1'b1, 32'hFFF0BDC0, 32'h00000000},
    {1'b0, 32'h00000000, 32'hFFF0BDC0},
    {1'b0, 32'h002DC6C0, 32'h003D0900},
    {1'b1, 32'hFFD23940, 32'h003D0900},
    {1'b0, 32'hFFD23940, 32'hFFC2F700},
    {1'b1, 32'h002DC6C0, 32'hFFC2F700},
    {1'b0, 32'h7FFFFFFF, 32'h00000000},
    {1'b0, 32'h80000001, 32'h00000000},
    {1'b0, 32'h40000000, 32'h40000000},
    {1'b1, 32'h12345678, 32'hF89ABCDF},
    {1'b0, 32'hFFFFFFFB, 32'h00000007},
    {1'b1, 32'h60000000, 32'h60000000},
    {1'b0, 32'h80000000, 32'h80000000},
    {1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        sel_b = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        done;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  polar_conv #(.ITER(ITER)) uut (
    .clk(clk), .rst(rst), .start(start), .sel_b(sel_b),
    .op_a(op_a), .op_b(op_b), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_polar(input logic [63:0] v, input logic [63:0] res, input string req);
    real re, im, m, a_exp, a_got, d, tol;
    logic [31:0] m_exp;
    re = real'($signed(v[63:32]));
    im = real'($signed(v[31:0]));
    m  = $sqrt(re * re + im * im);
    if (m > 2147483647.0) begin
      check(res[63:32] == 32'h7FFF_FFFF, "R6", {req, " saturated magnitude"},
            64'(res[63:32]), 64'h7FFF_FFFF);
    end else begin
      m_exp = 32'($rtoi(m + 0.5));
      d = real'(res[63:32]) - m;
      tol = 4.0 + m / 16777216.0;
      check(d <= tol && d >= -tol, "R3", {req, " magnitude"}, 64'(res[63:32]), 64'(m_exp));
    end
    if (m > 0.0) begin
      a_exp = $atan2(im, re) * 2147483648.0 / PI;
      a_got = real'($signed(res[31:0]));
      d = a_got - a_exp;
      while (d > 2147483648.0)  d = d - 4294967296.0;
      while (d < -2147483648.0) d = d + 4294967296.0;
      tol = 256.0 + 2147483648.0 / m;
      check(d <= tol && d >= -tol, "R4", {req, " angle"}, 64'(res[31:0]),
            64'(32'($rtoi(a_exp))));
    end
  endtask

  task automatic run_conv(input logic [63:0] a, input logic [63:0] b, input logic s,
                          output logic [63:0] res, output int lat);
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    sel_b = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] res, held;
    int lat, extra;

    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    check(result == 64'd0, "R1", "result in reset", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && result == 64'd0, "R1", "state after reset", result, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      v = VEC[i][63:0];
      // R2: the unselected operand carries different data
      if (VEC[i][64]) run_conv(~v, v, 1'b1, res, lat);
      else            run_conv(v, ~v, 1'b0, res, lat);
      check(lat == ITER + 2, "R8", "latency", 64'(lat), 64'(ITER + 2));
      check_polar(v, res, (i == 2 || i == 5 || i == 6) ? "R5 R2" : "R2");
      @(negedge clk);
      check(done == 1'b0, "R8", "done pulse width", 64'(done), 64'd0);
    end

    // R5: negative real axis gives exactly half turn
    run_conv({32'hC0000000, 32'h0}, 64'd0, 1'b0, res, lat);
    check(res[31:0] - 32'h8000_0000 + 32'd16 <= 32'd32, "R5", "angle on -real axis",
          64'(res[31:0]), 64'h8000_0000);

    // R7: zero operand, both select settings
    run_conv(64'd0, 64'h0001_0000_0002_0000, 1'b0, res, lat);
    check(res == 64'd0, "R7", "zero via op_a", res, 64'd0);
    run_conv(64'h0123_4567_0000_0001, 64'd0, 1'b1, res, lat);
    check(res == 64'd0, "R7", "zero via op_b", res, 64'd0);

    // R9: second request mid-conversion is dropped
    @(negedge clk);
    op_a = {32'h002DC6C0, 32'h003D0900};
    sel_b = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    op_b = {32'hFFD23940, 32'hFFC2F700};
    sel_b = 1'b1;
    start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(lat == ITER + 2, "R9", "latency unaffected", 64'(lat), 64'(ITER + 2));
    check_polar({32'h002DC6C0, 32'h003D0900}, result, "R9");
    extra = 0;
    repeat (45) begin @(negedge clk); if (done) extra++; end
    check(extra == 0, "R9", "no extra done", 64'(extra), 64'd0);

    // R10: result holds while idle and inputs move
    held = result;
    op_a = 64'hDEAD_BEEF_1234_5678;
    op_b = 64'h0BAD_F00D_8765_4321;
    sel_b = 1'b0;
    repeat (20) @(negedge clk);
    check(result == held, "R10", "result holds", result, held);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule